// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Page Write and Busy Polling

This block is a two-wire bus slave that behaves like a small serial EEPROM. SCL and SDA arrive as sampled inputs. The block never drives a line high: it only asserts a pull-low enable on SDA. It holds a byte array of `2**ADDR_W` locations. A master selects the block with a device address byte, then sends a two-byte word address followed by data bytes. The block can also read from the current address, or from a random address reached through a dummy write and a repeated start. In either case it streams bytes out in order until the master declines one.

Written bytes are held in a page buffer of `2**PAGE_W` bytes. During a write, only the offset inside the page moves, and it wraps back to the start of the same page. The array is updated only when a stop condition ends a write transfer cleanly. The block then enters a self-timed write cycle of `WR_CYCLES` clocks. During that cycle it ignores the bus completely and acknowledges nothing, so a master can find out when the cycle has finished by repeatedly sending its device address.

The control state machine, `twi_state_e`, has thirteen states:
- `ST_IDLE` waits for a start.
- Any start event outside `ST_BUSY` leads to `ST_START`. That state absorbs the SCL fall that follows the start, then moves to `ST_DEV`.
- `ST_DEV` collects eight bits. On a match it moves to `ST_DEV_ACK`; on a mismatch it returns to `ST_IDLE`.
- `ST_DEV_ACK` moves to `ST_RDAT` when the read bit is set, and to `ST_AHI` when it is clear.
- The write path runs `ST_AHI` → `ST_AHI_ACK` → `ST_ALO` → `ST_ALO_ACK` → `ST_WDAT`, then loops `ST_WDAT` ↔ `ST_WDAT_ACK`.
- The read path loops `ST_RDAT` ↔ `ST_RDAT_ACK`. A master NACK in `ST_RDAT_ACK` returns the machine to `ST_IDLE`.
- A stop in `ST_WDAT` with zero bits of the next byte received, and at least one byte buffered, moves to `ST_BUSY`. Any other stop moves to `ST_IDLE`.
- `ST_BUSY` returns to `ST_IDLE` after `WR_CYCLES` clocks.

Top module: `twi_eeprom`

## Requirements
- R1: The device address byte is sent MSB first as 1010, then three select bits, then a read/write bit (1 = read). The block acknowledges this byte only when the select bits equal `pin_addr_i`. Otherwise it acknowledges nothing until the next start.
- R2: The word address is two bytes, high byte first. Only the low `ADDR_W` bits of the combined 16-bit value select a location. With `ADDR_W`=9, address 0xFE05 reaches the same byte as 0x0005.
- R3: During a write, each data byte advances only the low `PAGE_W` bits of the address. After the last byte of a page, the next byte lands on the first byte of the same page.
- R4: If more than `2**PAGE_W` data bytes are sent in one write, the later bytes replace the earlier ones at the same page offsets.
- R5: Data reaches the array only when a stop ends a write. A stop after the word address but before any data byte, or a stop part-way through a data byte, writes nothing and does not start a write cycle.
- R6: After a committed write, the block stays busy for `WR_CYCLES` clocks. While busy, it never pulls SDA low, including for its own device address.
- R7: Once the write cycle is over, a start followed by the matching device address is acknowledged. The read/write bit of that byte then chooses whether a read or a write follows.
- R8: A random read works as follows: a write-mode device byte, two address bytes, a repeated start, and a read-mode device byte. The block then returns the byte at that address.
- R9: A sequential read increments over the full array address, not only within a page, and wraps from the last location to location 0.
- R10: A current-address read starts at the location after the last byte accessed. After a page write, this is the page offset that follows the last byte written, inside that page.
- R11: When the master does not acknowledge a read byte, the block releases SDA and waits for a new start.
- R12: After reset, SDA is released, every array byte reads 0, and the current address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| pin_addr_i | input | 3 | Strapped select bits compared with the device address byte |
| sda_pull_o | output | 1 | When high, the block pulls SDA low (ACK or a 0 data bit) |

## Verification
The block registers SCL and SDA through one stage and acts on the change one register later. An ACK or a read data bit therefore appears on SDA within two clocks of the SCL fall that calls for it. A write cycle ends `WR_CYCLES` clocks after the block sees the stop, which is about two clocks after SDA rises.

The bench keeps every SCL low phase six clocks long and changes SDA three clocks after a fall. It samples the ACK slot and read bits two clocks into the four-clock high phase, so each result has settled well before it is read.

Write cycle length is checked by counting device-address polls. The first poll after a stop must be refused, and a later poll must be accepted within a bounded number of attempts.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK,
        ST_BUSY
    } twi_state_e;

    // fixed device-type nibble that heads every device address byte
    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/twi_line_sense.sv
module twi_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic sda_now
);
    logic scl_s1, scl_s2, sda_s1, sda_s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_s1 <= 1'b1;
            scl_s2 <= 1'b1;
            sda_s1 <= 1'b1;
            sda_s2 <= 1'b1;
        end else begin
            scl_s1 <= scl_i;
            scl_s2 <= scl_s1;
            sda_s1 <= sda_i;
            sda_s2 <= sda_s1;
        end
    end

    // SDA edges are bus conditions only while SCL stays high
    assign scl_fall = !scl_s1 && scl_s2;
    assign start_ev = scl_s1 && scl_s2 && sda_s2 && !sda_s1;
    assign stop_ev  = scl_s1 && scl_s2 && !sda_s2 && sda_s1;
    assign sda_now  = sda_s1;

endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
    parameter int PAGE_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    load,
    input  logic [PAGE_W-1:0]       load_off,
    input  logic                    push,
    input  logic [7:0]              push_data,
    output logic [(2**PAGE_W)*8-1:0] data_flat,
    output logic [(2**PAGE_W)-1:0]   valid,
    output logic                    any_valid,
    output logic [PAGE_W-1:0]       next_off
);
    localparam int PAGE_BYTES = 2 ** PAGE_W;

    logic [PAGE_W-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (load) begin
            off_q <= load_off;
        end else if (push) begin
            off_q <= off_q + 1'b1;   // wraps within the page
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [7:0] byte_q;
        logic       vld_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else if (clr) begin
                vld_q  <= 1'b0;
            end else if (push && off_q == PAGE_W'(g)) begin
                byte_q <= push_data;
                vld_q  <= 1'b1;
            end
        end
        assign data_flat[g*8 +: 8] = byte_q;
        assign valid[g]            = vld_q;
    end

    assign any_valid = |valid;
    assign next_off  = off_q;

    // R3: offset leaves the last slot of the page back to slot 0
    p_offset_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !load && off_q == {PAGE_W{1'b1}}) |=> (off_q == '0));

    // R4: a pushed byte always occupies the slot it was aimed at
    p_push_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |=> valid[$past(off_q)]);

endmodule

// File: rtl/twi_eeprom_array.sv
module twi_eeprom_array #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  logic [ADDR_W-PAGE_W-1:0]  page,
    input  logic [(2**PAGE_W)*8-1:0]  data_flat,
    input  logic [(2**PAGE_W)-1:0]    valid,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [7:0]                rd_data
);
    localparam int DEPTH      = 2 ** ADDR_W;
    localparam int PAGE_BYTES = 2 ** PAGE_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (valid[i]) mem[{page, PAGE_W'(i)}] <= data_flat[i*8 +: 8];
            end
        end
    end

    assign rd_data = mem[rd_addr];

    // R5: a committed slot is visible in the array the following cycle
    p_commit_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && valid[0]) |=> (mem[{$past(page), PAGE_W'(0)}] == $past(data_flat[7:0])));

endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
    import twi_eeprom_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] pin_addr_i,
    output logic       sda_pull_o
);
    localparam int PAGE_BYTES = 2 ** PAGE_W;
    localparam int PAGE_IDX_W = ADDR_W - PAGE_W;
    localparam int HI_USED    = ADDR_W - 8;
    localparam int CNT_W      = $clog2(WR_CYCLES + 1);

    twi_state_e state_q, state_d;

    logic [2:0]        bit_q;
    logic [6:0]        sh_q;
    logic [HI_USED-1:0] hi_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [CNT_W-1:0]  wr_cnt_q;

    logic scl_fall, start_ev, stop_ev, sda_now;
    logic commit, pb_clr, pb_load, pb_push, rd_adv;
    logic [7:0] byte_in, rd_data;
    logic       last_bit, bit_state;

    logic [PAGE_BYTES*8-1:0] pb_data;
    logic [PAGE_BYTES-1:0]   pb_valid;
    logic                    pb_any;
    logic [PAGE_W-1:0]       pb_next_off;

    twi_line_sense u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_now  (sda_now)
    );

    twi_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pb_clr),
        .load      (pb_load),
        .load_off  (byte_in[PAGE_W-1:0]),
        .push      (pb_push),
        .push_data (byte_in),
        .data_flat (pb_data),
        .valid     (pb_valid),
        .any_valid (pb_any),
        .next_off  (pb_next_off)
    );

    twi_eeprom_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .page      (cur_addr_q[ADDR_W-1:PAGE_W]),
        .data_flat (pb_data),
        .valid     (pb_valid),
        .rd_addr   (cur_addr_q),
        .rd_data   (rd_data)
    );

    // a bit is taken at each SCL fall from the level held while SCL was high
    assign byte_in   = {sh_q, sda_now};
    assign last_bit  = (bit_q == 3'd7);
    assign bit_state = (state_q == ST_DEV)  || (state_q == ST_AHI) ||
                       (state_q == ST_ALO)  || (state_q == ST_WDAT) ||
                       (state_q == ST_RDAT);

    // next state and control strobes
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        pb_clr  = 1'b0;
        pb_load = 1'b0;
        pb_push = 1'b0;
        rd_adv  = 1'b0;
        if (state_q == ST_BUSY) begin
            if (wr_cnt_q == CNT_W'(WR_CYCLES - 1)) state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_START;
            pb_clr  = 1'b1;
        end else if (stop_ev) begin
            if (state_q == ST_WDAT && bit_q == 3'd0 && pb_any) begin
                commit  = 1'b1;
                state_d = ST_BUSY;
            end else begin
                state_d = ST_IDLE;
            end
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_START:    state_d = ST_DEV;
                ST_DEV: if (last_bit) begin
                    state_d = (byte_in[7:4] == DEV_TYPE && byte_in[3:1] == pin_addr_i)
                              ? ST_DEV_ACK : ST_IDLE;
                end
                ST_DEV_ACK:  state_d = sh_q[0] ? ST_RDAT : ST_AHI;
                ST_AHI:      if (last_bit) state_d = ST_AHI_ACK;
                ST_AHI_ACK:  state_d = ST_ALO;
                ST_ALO: if (last_bit) begin
                    state_d = ST_ALO_ACK;
                    pb_load = 1'b1;
                end
                ST_ALO_ACK:  state_d = ST_WDAT;
                ST_WDAT: if (last_bit) begin
                    state_d = ST_WDAT_ACK;
                    pb_push = 1'b1;
                end
                ST_WDAT_ACK: state_d = ST_WDAT;
                ST_RDAT: if (last_bit) begin
                    state_d = ST_RDAT_ACK;
                    rd_adv  = 1'b1;
                end
                ST_RDAT_ACK: state_d = sda_now ? ST_IDLE : ST_RDAT;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bit_q      <= '0;
            sh_q       <= '0;
            hi_q       <= '0;
            cur_addr_q <= '0;
            wr_cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)         bit_q <= '0;
            else if (scl_fall && bit_state) bit_q <= bit_q + 1'b1;
            if (scl_fall && bit_state)      sh_q  <= byte_in[6:0];
            if (scl_fall && state_q == ST_AHI && last_bit && !start_ev && !stop_ev)
                hi_q <= byte_in[HI_USED-1:0];
            if (pb_load)
                cur_addr_q <= {hi_q, byte_in};
            else if (commit)
                cur_addr_q <= {cur_addr_q[ADDR_W-1:PAGE_W], pb_next_off};
            else if (rd_adv)
                cur_addr_q <= cur_addr_q + 1'b1;
            wr_cnt_q <= (state_q == ST_BUSY) ? wr_cnt_q + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_pull_o = 1'b1;
            ST_RDAT: sda_pull_o = !rd_data[3'd7 - bit_q];
            default: sda_pull_o = 1'b0;
        endcase
    end

    // R6: no pull on SDA at all while the write cycle runs
    p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |-> !sda_pull_o);

    // R6: the write cycle never outlasts its configured length
    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |-> (wr_cnt_q < CNT_W'(WR_CYCLES)));

    // R1: device ACK only follows a byte carrying the type nibble and matching pins
    p_ack_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_ACK) |-> (sh_q[6:1] == {DEV_TYPE[2:0], pin_addr_i}));

    // R3: a data byte does not move the stored page row
    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDAT_ACK && $past(state_q) == ST_WDAT) |-> $stable(cur_addr_q));

    // R9: the read pointer wraps from the top of the array to 0
    p_seq_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_adv && cur_addr_q == {ADDR_W{1'b1}}) |=> (cur_addr_q == '0));

    // R5: the write cycle is entered only from a stop with data buffered
    p_busy_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && $past(state_q) != ST_BUSY) |-> $past(stop_ev && pb_any));

endmodule

// File: tb/twi_eeprom_bench.sv
module twi_eeprom_bench;

    localparam int WR_CYC = 400;
    localparam logic [2:0] PINS  = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, PINS, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, PINS, 1'b1};

    // stimulus vectors: {write address, read-back address, data}
    localparam int NV = 6;
    localparam logic [39:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 8'h11},
        {16'hFE05, 16'h0005, 8'h22},
        {16'h0022, 16'h0022, 8'h5A},
        {16'h01FE, 16'h01FE, 8'h3C},
        {16'hFFFF, 16'h01FF, 8'h4D},
        {16'h0180, 16'h0180, 8'h66}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_pull = 1'b0;
    logic sda_pull;
    logic sda_line;
    int   tests = 0;
    int   failed = 0;
    bit   done = 1'b0;
    logic [7:0] rbuf [40];

    always #2 clk = ~clk;

    assign sda_line = !(m_pull || sda_pull);

    twi_eeprom #(.ADDR_W(9), .PAGE_W(5), .WR_CYCLES(WR_CYC)) u_twi_eeprom (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .pin_addr_i (PINS),
        .sda_pull_o (sda_pull)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        if (!scl) begin
            m_pull = 1'b0; hold(3);
            scl = 1'b1;    hold(4);
        end
        m_pull = 1'b1; hold(4);
        scl = 1'b0;    hold(3);
    endtask

    task automatic bus_stop;
        m_pull = 1'b1; hold(3);
        scl = 1'b1;    hold(4);
        m_pull = 1'b0; hold(6);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_pull = !b[i]; hold(3);
            scl = 1'b1;     hold(4);
            scl = 1'b0;     hold(3);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_pull = 1'b0; hold(3);
        scl = 1'b1;    hold(2);
        ack = !sda_line;
        hold(2);
        scl = 1'b0;    hold(3);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            hold(3);
            scl = 1'b1; hold(2);
            b[i] = sda_line;
            hold(2);
            scl = 1'b0;
        end
        hold(3);
        m_pull = give_ack; hold(3);
        scl = 1'b1;        hold(4);
        scl = 1'b0;        hold(3);
        m_pull = 1'b0;
    endtask

    task automatic addr_write(input logic [15:0] a, output bit ok);
        bit a0, a1, a2;
        bus_start;
        send_byte(DEV_W, a0);
        send_byte(a[15:8], a1);
        send_byte(a[7:0], a2);
        ok = a0 && a1 && a2;
    endtask

    task automatic poll(input bit rd, output int tries);
        bit ack = 1'b0;
        tries = 0;
        while (!ack && tries < 40) begin
            tries++;
            bus_start;
            send_byte(rd ? DEV_R : DEV_W, ack);
            if (!ack) bus_stop;
        end
    endtask

    // random read of n bytes; last byte not acknowledged
    task automatic read_seq(input logic [15:0] a, input int n);
        bit ok, ack;
        addr_write(a, ok);
        bus_start;
        send_byte(DEV_R, ack);
        check(ok && ack, "R8 random read address phase ack", int'(ok && ack), 1);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        hold(1);
        check(sda_line == 1'b1, "R11 SDA released after master NACK", int'(sda_line), 1);
        bus_stop;
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failed++;
            tests++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            report;
        end
    end

    initial begin
        bit ack, ok;
        int tries;

        // ---------------- reset state (R12)
        hold(5);
        check(sda_line == 1'b1, "R12 SDA released in reset", int'(sda_line), 1);
        rst_n = 1'b1;
        hold(5);

        // current-address read straight after reset: address 0, value 0 (R10, R12)
        bus_start;
        send_byte(DEV_R, ack);
        check(ack, "R1 matching read address acknowledged", int'(ack), 1);
        recv_byte(1'b0, rbuf[0]);
        check(rbuf[0] == 8'h00, "R12 array zero at address 0 after reset", rbuf[0], 0);
        bus_stop;

        // ---------------- wrong select bits are ignored (R1)
        bus_start;
        send_byte({4'b1010, 3'b001, 1'b0}, ack);
        check(!ack, "R1 mismatched select bits not acknowledged", int'(ack), 0);
        send_byte(8'h00, ack);
        check(!ack, "R1 bytes after mismatch ignored", int'(ack), 0);
        bus_stop;

        // ---------------- vector table: byte write, poll, random read (R2, R6, R7, R8)
        for (int v = 0; v < NV; v++) begin
            logic [15:0] wa, ra;
            logic [7:0]  dv;
            bit          d_ack;
            wa = VEC[v][39:24];
            ra = VEC[v][23:8];
            dv = VEC[v][7:0];
            addr_write(wa, ok);
            send_byte(dv, d_ack);
            check(ok && d_ack, "R2 byte write acknowledged", int'(ok && d_ack), 1);
            bus_stop;
            poll(1'b0, tries);
            check(tries > 1 && tries < 40, "R6 poll refused then accepted", tries, 2);
            bus_stop;
            read_seq(ra, 1);
            check(rbuf[0] == dv, "R2 R8 read-back at masked address", rbuf[0], dv);
        end

        // ---------------- page wrap (R3), busy NACK (R6), read after poll (R7, R10)
        addr_write(16'h003E, ok);
        send_byte(8'hC1, ack);
        send_byte(8'hC2, ack);
        send_byte(8'hC3, ack);
        send_byte(8'hC4, ack);
        bus_stop;
        poll(1'b1, tries);
        check(tries > 1 && tries < 40, "R6 no ACK during write cycle", tries, 2);
        recv_byte(1'b0, rbuf[0]);
        check(rbuf[0] == 8'h5A, "R7 R10 current read at next page offset 0x022", rbuf[0], 8'h5A);
        bus_stop;
        read_seq(16'h003E, 3);
        check(rbuf[0] == 8'hC1, "R3 first byte at 0x03E", rbuf[0], 8'hC1);
        check(rbuf[1] == 8'hC2, "R3 second byte at 0x03F", rbuf[1], 8'hC2);
        check(rbuf[2] == 8'h00, "R9 sequential read crosses page to 0x040", rbuf[2], 0);
        read_seq(16'h0020, 2);
        check(rbuf[0] == 8'hC3, "R3 third byte wrapped to 0x020", rbuf[0], 8'hC3);
        check(rbuf[1] == 8'hC4, "R3 fourth byte at 0x021", rbuf[1], 8'hC4);

        // ---------------- more than a page in one write (R4)
        addr_write(16'h0040, ok);
        for (int k = 0; k < 34; k++) send_byte(8'h80 + 8'(k), ack);
        bus_stop;
        poll(1'b0, tries);
        bus_stop;
        read_seq(16'h0040, 3);
        check(rbuf[0] == 8'hA0, "R4 slot 0 overwritten by byte 32", rbuf[0], 8'hA0);
        check(rbuf[1] == 8'hA1, "R4 slot 1 overwritten by byte 33", rbuf[1], 8'hA1);
        check(rbuf[2] == 8'h82, "R4 slot 2 keeps byte 2", rbuf[2], 8'h82);
        read_seq(16'h005F, 1);
        check(rbuf[0] == 8'h9F, "R4 last slot keeps byte 31", rbuf[0], 8'h9F);

        // ---------------- stop before data and mid-byte (R5)
        addr_write(16'h0100, ok);
        bus_stop;
        bus_start;
        send_byte(DEV_W, ack);
        check(ack, "R5 no write cycle after stop before data", int'(ack), 1);
        bus_stop;
        read_seq(16'h0100, 1);
        check(rbuf[0] == 8'h00, "R5 nothing written at 0x100", rbuf[0], 0);

        addr_write(16'h0101, ok);
        send_bits(8'hFF, 4);
        bus_stop;
        bus_start;
        send_byte(DEV_W, ack);
        check(ack, "R5 no write cycle after mid-byte stop", int'(ack), 1);
        bus_stop;
        read_seq(16'h0101, 1);
        check(rbuf[0] == 8'h00, "R5 nothing written at 0x101", rbuf[0], 0);

        // ---------------- sequential read wraps the array (R9)
        read_seq(16'h01FE, 3);
        check(rbuf[0] == 8'h3C, "R9 read 0x1FE", rbuf[0], 8'h3C);
        check(rbuf[1] == 8'h4D, "R9 read 0x1FF", rbuf[1], 8'h4D);
        check(rbuf[2] == 8'h11, "R9 wrap to 0x000", rbuf[2], 8'h11);

        // current-address read continues after a read (R10)
        bus_start;
        send_byte(DEV_R, ack);
        recv_byte(1'b0, rbuf[0]);
        bus_stop;
        check(rbuf[0] == 8'h00, "R10 current read follows last read at 0x001", rbuf[0], 0);

        done = 1'b1;
        report;
    end

endmodule